// File: doc/BRIEF.md
# Matrix Key Event Generator with Ghost Rejection

This block sits behind a keyboard matrix scanner. It takes one snapshot of up to `ENTRIES` key slots at a time. Each slot has its own valid bit, a row number and a column number. The block keeps the set of keys it accepted last. For each new snapshot it produces a serial stream of key events. Each event carries a press or release flag and a scancode. After the last event of an accepted snapshot the block raises a one-cycle sync pulse, so the consumer can close the frame.

Two options shape the result:

- **Ghost rejection.** When the matrix shows a shape that can only come from ghosting, the whole snapshot is thrown away. Nothing is emitted and nothing is changed.
- **Function key.** A configured function key can move every other key of the snapshot into a second scancode bank. The function key itself is never reported.

The scanner's "nothing buffered" condition enters through the same port as a snapshot, with an empty flag set. It releases every key still held.

Top module: `kge_event_gen`

## Requirements
- R1: An event scancode is `row * 2**COL_W + col`, where `COL_W = log2(NUM_COLS)`. When the function key is in effect, `MAX_KEYS = NUM_ROWS*NUM_COLS` is added. With the default sizes, row 5 column 3 gives 43.
- R2: Each held key whose scancode is absent from the new snapshot's scancodes gets one release event (`evt_press`=0). Releases come in held order, and all of them come before any press event.
- R3: Each valid, non-function slot of an accepted snapshot gets one press event (`evt_press`=1), lowest slot first. The resulting scancode list then becomes the held set.
- R4: With `cfg_fn_en`=1, a valid slot equal to (`cfg_fn_row`, `cfg_fn_col`) is the function key. It produces no event, it does not count as a key, and its presence adds `MAX_KEYS` to every other scancode. With `cfg_fn_en`=0 that slot is an ordinary key.
- R5: With `cfg_ghost_en`=1, a snapshot is dropped when it holds three or more non-function keys, some pair of them shares a row, and some pair shares a column. A dropped snapshot emits no event and no sync, and it leaves the held set unchanged.
- R6: A snapshot is processed normally when `cfg_ghost_en`=0, or when it has fewer than three keys, or when its keys share rows only or columns only.
- R7: A snapshot with `snap_empty`=1 ignores its slots. It releases every held key and leaves the held set empty.
- R8: While `evt_valid`=1 and `evt_ready`=0, `evt_valid`, `evt_press` and `evt_code` hold their values.
- R9: `evt_sync` pulses for exactly one cycle after the final event of every accepted snapshot, including one that yields no events.
- R10: `snap_ready` is 0 from the acceptance of a snapshot until the sync pulse or the drop has completed. It is never 1 while `evt_valid` is 1.
- R11: After reset, `snap_ready`=1, `evt_valid`=0, `evt_sync`=0 and the held set is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ghost_en | input | 1 | Enables ghost rejection, sampled with each snapshot |
| cfg_fn_en | input | 1 | Enables function-key banking, sampled with each snapshot |
| cfg_fn_row | input | ROW_W | Row of the function key |
| cfg_fn_col | input | COL_W | Column of the function key |
| snap_valid | input | 1 | Snapshot offered |
| snap_ready | output | 1 | Block can take a snapshot |
| snap_empty | input | 1 | Snapshot stands for an empty scanner buffer |
| snap_key_vld | input | ENTRIES | Per-slot valid bits |
| snap_key_row | input | ENTRIES*ROW_W | Per-slot row numbers, slot 0 in the low bits |
| snap_key_col | input | ENTRIES*COL_W | Per-slot column numbers, slot 0 in the low bits |
| evt_valid | output | 1 | Event offered |
| evt_ready | input | 1 | Consumer takes the event |
| evt_press | output | 1 | 1 for press, 0 for release |
| evt_code | output | CODE_W | Event scancode |
| evt_sync | output | 1 | One-cycle frame end after an accepted snapshot |

## Verification
The hardest case to reach from the ports is a ghost drop that happens while the held set is non-empty. A wrong design that updates the held set or emits events on a drop can look correct until a later snapshot exposes it. The directed part of the stimulus first loads a held set, then offers an L-shaped three-key pattern, and then offers a fresh snapshot whose release list shows whether the old set survived. The random part keeps rows and columns in a 4x4 corner and places the function key inside it. This makes row and column sharing, function-key banking and overlapping held and new sets frequent, while consumer stalls are drawn at random.

// File: rtl/kge_pkg.sv
package kge_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PREP,
      ST_REL,
      ST_PRS,
      ST_SYNC
   } kge_state_e;

endpackage

// File: rtl/kge_snapshot_prep.sv
module kge_snapshot_prep #(
   parameter int ENTRIES  = 8,
   parameter int ROW_W    = 4,
   parameter int COL_W    = 3,
   parameter int CODE_W   = 8,
   parameter int MAX_KEYS = 128,
   parameter int CNT_W    = 4
) (
   input  logic [ENTRIES-1:0]        vld,
   input  logic [ENTRIES*ROW_W-1:0]  rows,
   input  logic [ENTRIES*COL_W-1:0]  cols,
   input  logic                      force_empty,
   input  logic                      fn_en,
   input  logic [ROW_W-1:0]          fn_row,
   input  logic [COL_W-1:0]          fn_col,
   input  logic                      ghost_en,
   output logic [ENTRIES*CODE_W-1:0] key_codes,
   output logic [CNT_W-1:0]          key_cnt,
   output logic                      ghost_drop
);

   logic [ENTRIES-1:0] is_fn;
   logic [ENTRIES-1:0] is_key;
   logic [CODE_W-1:0]  slot_code [ENTRIES];
   logic               fn_any;
   logic               share_row;
   logic               share_col;

   assign fn_any = (|is_fn) & ~force_empty;

   // per-slot decode and scancode formation
   for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_slot
      logic [ROW_W-1:0] r;
      logic [COL_W-1:0] c;
      assign r = rows[gi*ROW_W +: ROW_W];
      assign c = cols[gi*COL_W +: COL_W];
      assign is_fn[gi]  = vld[gi] & fn_en & (r == fn_row) & (c == fn_col);
      assign is_key[gi] = vld[gi] & ~is_fn[gi] & ~force_empty;
      assign slot_code[gi] = CODE_W'({r, c}) + (fn_any ? CODE_W'(MAX_KEYS) : CODE_W'(0));
   end

   // compaction into a dense list, lowest slot first
   always_comb begin
      int pos;
      pos = 0;
      key_codes = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (is_key[i]) begin
            key_codes[pos*CODE_W +: CODE_W] = slot_code[i];
            pos = pos + 1;
         end
      end
      key_cnt = CNT_W'(pos);
   end

   // pairwise row/column sharing among counted keys
   always_comb begin
      share_row = 1'b0;
      share_col = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         for (int j = i + 1; j < ENTRIES; j++) begin
            if (is_key[i] && is_key[j]) begin
               if (rows[i*ROW_W +: ROW_W] == rows[j*ROW_W +: ROW_W]) share_row = 1'b1;
               if (cols[i*COL_W +: COL_W] == cols[j*COL_W +: COL_W]) share_col = 1'b1;
            end
         end
      end
   end

   assign ghost_drop = ghost_en & (key_cnt >= CNT_W'(3)) & share_row & share_col;

endmodule

// File: rtl/kge_member_cmp.sv
module kge_member_cmp #(
   parameter int ENTRIES = 8,
   parameter int CODE_W  = 8,
   parameter int CNT_W   = 4
) (
   input  logic [CODE_W-1:0]         probe,
   input  logic [ENTRIES*CODE_W-1:0] list,
   input  logic [CNT_W-1:0]          list_cnt,
   output logic                      hit
);

   logic [ENTRIES-1:0] slot_hit;

   for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
      assign slot_hit[gi] = (CNT_W'(gi) < list_cnt) &&
                            (list[gi*CODE_W +: CODE_W] == probe);
   end

   assign hit = |slot_hit;

endmodule

// File: rtl/kge_event_gen.sv
module kge_event_gen
   import kge_pkg::*;
#(
   parameter int ENTRIES  = 8,
   parameter int NUM_ROWS = 16,
   parameter int NUM_COLS = 8,
   parameter int ROW_W    = $clog2(NUM_ROWS),
   parameter int COL_W    = $clog2(NUM_COLS),
   parameter int CODE_W   = $clog2(2 * NUM_ROWS * NUM_COLS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_ghost_en,
   input  logic                     cfg_fn_en,
   input  logic [ROW_W-1:0]         cfg_fn_row,
   input  logic [COL_W-1:0]         cfg_fn_col,
   input  logic                     snap_valid,
   output logic                     snap_ready,
   input  logic                     snap_empty,
   input  logic [ENTRIES-1:0]       snap_key_vld,
   input  logic [ENTRIES*ROW_W-1:0] snap_key_row,
   input  logic [ENTRIES*COL_W-1:0] snap_key_col,
   output logic                     evt_valid,
   input  logic                     evt_ready,
   output logic                     evt_press,
   output logic [CODE_W-1:0]        evt_code,
   output logic                     evt_sync
);

   localparam int MAX_KEYS = NUM_ROWS * NUM_COLS;
   localparam int CNT_W    = $clog2(ENTRIES + 1);

   initial begin
      assert (NUM_COLS == (1 << COL_W)) else $error("NUM_COLS must be a power of two matching COL_W");
      assert (ROW_W == $clog2(NUM_ROWS)) else $error("ROW_W does not match NUM_ROWS");
      assert (CODE_W >= $clog2(2 * MAX_KEYS)) else $error("CODE_W too narrow for two banks");
      assert (ENTRIES >= 1) else $error("ENTRIES must be positive");
   end

   kge_state_e                state_q;
   logic [ENTRIES-1:0]        raw_vld_q;
   logic [ENTRIES*ROW_W-1:0]  raw_row_q;
   logic [ENTRIES*COL_W-1:0]  raw_col_q;
   logic                      raw_empty_q;
   logic                      ghost_en_q;
   logic                      fn_en_q;
   logic [ROW_W-1:0]          fn_row_q;
   logic [COL_W-1:0]          fn_col_q;
   logic [ENTRIES*CODE_W-1:0] held_q;
   logic [CNT_W-1:0]          held_cnt_q;
   logic [CNT_W-1:0]          idx_q;

   logic [ENTRIES*CODE_W-1:0] new_codes;
   logic [CNT_W-1:0]          new_cnt;
   logic                      drop;
   logic [CNT_W-1:0]          idx_safe;
   logic [CODE_W-1:0]         held_cur;
   logic [CODE_W-1:0]         new_cur;
   logic                      held_hit;
   logic                      rel_done;
   logic                      prs_done;

   kge_snapshot_prep #(
      .ENTRIES  (ENTRIES),
      .ROW_W    (ROW_W),
      .COL_W    (COL_W),
      .CODE_W   (CODE_W),
      .MAX_KEYS (MAX_KEYS),
      .CNT_W    (CNT_W)
   ) u_prep (
      .vld         (raw_vld_q),
      .rows        (raw_row_q),
      .cols        (raw_col_q),
      .force_empty (raw_empty_q),
      .fn_en       (fn_en_q),
      .fn_row      (fn_row_q),
      .fn_col      (fn_col_q),
      .ghost_en    (ghost_en_q),
      .key_codes   (new_codes),
      .key_cnt     (new_cnt),
      .ghost_drop  (drop)
   );

   assign idx_safe = (idx_q < CNT_W'(ENTRIES)) ? idx_q : '0;
   assign held_cur = held_q[int'(idx_safe)*CODE_W +: CODE_W];
   assign new_cur  = new_codes[int'(idx_safe)*CODE_W +: CODE_W];
   assign rel_done = (idx_q >= held_cnt_q);
   assign prs_done = (idx_q >= new_cnt);

   kge_member_cmp #(
      .ENTRIES (ENTRIES),
      .CODE_W  (CODE_W),
      .CNT_W   (CNT_W)
   ) u_member (
      .probe    (held_cur),
      .list     (new_codes),
      .list_cnt (new_cnt),
      .hit      (held_hit)
   );

   // event presentation
   always_comb begin
      evt_valid = 1'b0;
      evt_press = 1'b0;
      evt_code  = '0;
      unique case (state_q)
         ST_REL: begin
            evt_valid = ~rel_done & ~held_hit;
            evt_press = 1'b0;
            evt_code  = held_cur;
         end
         ST_PRS: begin
            evt_valid = ~prs_done;
            evt_press = 1'b1;
            evt_code  = new_cur;
         end
         default: ;
      endcase
   end

   assign snap_ready = (state_q == ST_IDLE);
   assign evt_sync   = (state_q == ST_SYNC);

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         raw_vld_q   <= '0;
         raw_row_q   <= '0;
         raw_col_q   <= '0;
         raw_empty_q <= 1'b0;
         ghost_en_q  <= 1'b0;
         fn_en_q     <= 1'b0;
         fn_row_q    <= '0;
         fn_col_q    <= '0;
         held_q      <= '0;
         held_cnt_q  <= '0;
         idx_q       <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (snap_valid) begin
                  raw_vld_q   <= snap_key_vld;
                  raw_row_q   <= snap_key_row;
                  raw_col_q   <= snap_key_col;
                  raw_empty_q <= snap_empty;
                  ghost_en_q  <= cfg_ghost_en;
                  fn_en_q     <= cfg_fn_en;
                  fn_row_q    <= cfg_fn_row;
                  fn_col_q    <= cfg_fn_col;
                  state_q     <= ST_PREP;
               end
            end
            ST_PREP: begin
               idx_q   <= '0;
               state_q <= drop ? ST_IDLE : ST_REL;
            end
            ST_REL: begin
               if (rel_done) begin
                  idx_q   <= '0;
                  state_q <= ST_PRS;
               end else if (held_hit || evt_ready) begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_PRS: begin
               if (prs_done) begin
                  state_q <= ST_SYNC;
               end else if (evt_ready) begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_SYNC: begin
               held_q     <= new_codes;
               held_cnt_q <= new_cnt;
               idx_q      <= '0;
               state_q    <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // checks beside the sequencing
   p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> !snap_ready);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_code) && $stable(evt_press)));

   p_sync_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_sync |=> !evt_sync);

   p_sync_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      evt_sync |=> snap_ready);

   p_drop_keeps_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PREP && drop) |=> ($stable(held_cnt_q) && $stable(held_q) && !evt_valid && !evt_sync));

   p_held_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      held_cnt_q <= CNT_W'(ENTRIES));

   p_empty_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_sync && raw_empty_q) |=> (held_cnt_q == '0));

endmodule

// File: tb/kge_event_gen_tb.sv
module kge_event_gen_tb;

   localparam int ENTRIES  = 8;
   localparam int NUM_ROWS = 16;
   localparam int NUM_COLS = 8;
   localparam int ROW_W    = 4;
   localparam int COL_W    = 3;
   localparam int CODE_W   = 8;
   localparam int MAX_KEYS = NUM_ROWS * NUM_COLS;
   localparam int MAXEV    = 2 * ENTRIES;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_ghost_en = 1'b0, cfg_fn_en = 1'b0;
   logic [ROW_W-1:0] cfg_fn_row = '0;
   logic [COL_W-1:0] cfg_fn_col = '0;
   logic snap_valid = 1'b0, snap_empty = 1'b0;
   logic snap_ready;
   logic [ENTRIES-1:0] snap_key_vld = '0;
   logic [ENTRIES*ROW_W-1:0] snap_key_row = '0;
   logic [ENTRIES*COL_W-1:0] snap_key_col = '0;
   logic evt_valid, evt_press, evt_sync;
   logic evt_ready = 1'b0;
   logic [CODE_W-1:0] evt_code;

   always #4 clk = ~clk;

   kge_event_gen #(.ENTRIES(ENTRIES), .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_ghost_en(cfg_ghost_en), .cfg_fn_en(cfg_fn_en),
      .cfg_fn_row(cfg_fn_row), .cfg_fn_col(cfg_fn_col),
      .snap_valid(snap_valid), .snap_ready(snap_ready), .snap_empty(snap_empty),
      .snap_key_vld(snap_key_vld), .snap_key_row(snap_key_row), .snap_key_col(snap_key_col),
      .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_press(evt_press),
      .evt_code(evt_code), .evt_sync(evt_sync)
   );

   int n_checks = 0;
   int n_fail   = 0;

   // model state
   int held [ENTRIES];
   int held_n = 0;
   // stimulus slots
   int s_vld [ENTRIES];
   int s_row [ENTRIES];
   int s_col [ENTRIES];
   // expected and observed
   int exp_code [MAXEV];
   int exp_prs  [MAXEV];
   int exp_n;
   int got_code [MAXEV];
   int got_prs  [MAXEV];
   int got_n;

   task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic int mk_code(input int r, input int c, input bit bank);
      return r * NUM_COLS + c + (bank ? MAX_KEYS : 0);
   endfunction

   task automatic clear_slots();
      for (int i = 0; i < ENTRIES; i++) begin
         s_vld[i] = 0; s_row[i] = 0; s_col[i] = 0;
      end
   endtask

   // builds expectation; returns 1 when the snapshot is to be dropped
   task automatic model(input bit empty, input bit gen, input bit fen, input int fr, input int fc,
                        output bit drop, output int nk, output int nlist [ENTRIES]);
      bit isfn [ENTRIES];
      bit iskey [ENTRIES];
      bit fany;
      bit srow;
      bit scol;
      fany = 0; srow = 0; scol = 0; nk = 0;
      for (int i = 0; i < ENTRIES; i++) begin
         isfn[i]  = (s_vld[i] != 0) && fen && s_row[i] == fr && s_col[i] == fc;
         iskey[i] = (s_vld[i] != 0) && !isfn[i] && !empty;
         if (isfn[i] && !empty) fany = 1;
         nlist[i] = 0;
      end
      for (int i = 0; i < ENTRIES; i++) begin
         if (iskey[i]) begin
            nlist[nk] = mk_code(s_row[i], s_col[i], fany);
            nk++;
         end
         for (int j = i + 1; j < ENTRIES; j++) begin
            if (iskey[i] && iskey[j]) begin
               if (s_row[i] == s_row[j]) srow = 1;
               if (s_col[i] == s_col[j]) scol = 1;
            end
         end
      end
      drop = gen && nk >= 3 && srow && scol;
      exp_n = 0;
      if (!drop) begin
         for (int h = 0; h < held_n; h++) begin
            bit found;
            found = 0;
            for (int k = 0; k < nk; k++) if (nlist[k] == held[h]) found = 1;
            if (!found) begin
               exp_code[exp_n] = held[h]; exp_prs[exp_n] = 0; exp_n++;
            end
         end
         for (int k = 0; k < nk; k++) begin
            exp_code[exp_n] = nlist[k]; exp_prs[exp_n] = 1; exp_n++;
         end
      end
   endtask

   task automatic run_snap(input string tag, input bit empty, input bit gen, input bit fen,
                           input int fr, input int fc, input int ready_pct);
      bit drop;
      int nk;
      int nlist [ENTRIES];
      bit sync_seen;
      int sync_at;
      bit pend;
      int pend_code;
      int pend_prs;
      model(empty, gen, fen, fr, fc, drop, nk, nlist);
      @(negedge clk);
      for (int i = 0; i < ENTRIES; i++) begin
         snap_key_vld[i] = (s_vld[i] != 0);
         snap_key_row[i*ROW_W +: ROW_W] = ROW_W'(s_row[i]);
         snap_key_col[i*COL_W +: COL_W] = COL_W'(s_col[i]);
      end
      snap_empty = empty; cfg_ghost_en = gen; cfg_fn_en = fen;
      cfg_fn_row = ROW_W'(fr); cfg_fn_col = COL_W'(fc);
      snap_valid = 1'b1;
      #1;
      check(snap_ready == 1'b1, "R10", {tag, " ready before offer"}, int'(snap_ready), 1);
      got_n = 0; sync_seen = 0; sync_at = -1; pend = 0; pend_code = 0; pend_prs = 0;
      @(negedge clk);
      snap_valid = 1'b0;
      for (int cyc = 0; cyc < 200; cyc++) begin
         evt_ready = (($urandom % 100) < ready_pct);
         #1;
         if (pend) begin
            check(evt_valid && int'(evt_code) == pend_code && int'(evt_press) == pend_prs,
                  "R8", {tag, " stalled event changed"}, int'(evt_code), pend_code);
         end
         pend = 0;
         if (evt_valid && snap_ready)
            check(0, "R10", {tag, " ready high during event"}, 1, 0);
         if (evt_valid && !evt_ready) begin
            pend = 1; pend_code = int'(evt_code); pend_prs = int'(evt_press);
         end
         if (evt_valid && evt_ready && got_n < MAXEV) begin
            got_code[got_n] = int'(evt_code); got_prs[got_n] = int'(evt_press); got_n++;
         end
         if (evt_sync) begin
            if (sync_seen) check(0, "R9", {tag, " second sync"}, 2, 1);
            sync_seen = 1; sync_at = got_n;
         end
         if (snap_ready) break;
         @(negedge clk);
      end
      evt_ready = 1'b0;
      check(snap_ready == 1'b1, "R10", {tag, " back to ready"}, int'(snap_ready), 1);
      if (drop) begin
         check(got_n == 0, "R5", {tag, " events on dropped snapshot"}, got_n, 0);
         check(!sync_seen, "R5", {tag, " sync on dropped snapshot"}, int'(sync_seen), 0);
      end else begin
         check(sync_seen && sync_at == exp_n, "R9", {tag, " sync after last event"}, sync_at, exp_n);
         check(got_n == exp_n, "R3", {tag, " event count"}, got_n, exp_n);
         for (int k = 0; k < exp_n && k < got_n; k++) begin
            check(got_code[k] == exp_code[k] && got_prs[k] == exp_prs[k],
                  exp_prs[k] ? "R3" : "R2", {tag, " event code"}, got_code[k], exp_code[k]);
         end
         held_n = nk;
         for (int k = 0; k < ENTRIES; k++) held[k] = nlist[k];
      end
   endtask

   initial begin
      int wd;
      wd = 0;
      forever begin
         @(posedge clk);
         wd++;
         if (wd > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
         end
      end
   end

   initial begin
      int r;
      r = $urandom(32'd2024);
      for (int i = 0; i < ENTRIES; i++) held[i] = 0;
      repeat (3) @(negedge clk);
      #1;
      check(snap_ready == 1'b1 && evt_valid == 1'b0 && evt_sync == 1'b0, "R11", "reset outputs",
            int'({snap_ready, evt_valid, evt_sync}), 4);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: single key, and R11 empty held set gives no release
      clear_slots(); s_vld[2] = 1; s_row[2] = 5; s_col[2] = 3;
      run_snap("R1 single", 0, 1, 0, 0, 0, 100);
      check(got_n == 1 && got_code[0] == 43 && got_prs[0] == 1, "R1", "row5 col3 scancode", got_code[0], 43);
      check(got_n == 1, "R11", "no release from reset set", got_n, 1);

      // R2 and R3: overlap between sets, stalls on the consumer
      clear_slots(); s_vld[0] = 1; s_row[0] = 1; s_col[0] = 1; s_vld[5] = 1; s_row[5] = 7; s_col[5] = 6;
      run_snap("R3 pair", 0, 1, 0, 0, 0, 40);
      clear_slots(); s_vld[1] = 1; s_row[1] = 7; s_col[1] = 6; s_vld[3] = 1; s_row[3] = 2; s_col[3] = 0;
      run_snap("R2 overlap", 0, 1, 0, 0, 0, 30);
      check(got_n == 3 && got_prs[0] == 0 && got_code[0] == 9, "R2", "release first", got_code[0], 9);

      // R4: function key banking
      clear_slots(); s_vld[0] = 1; s_row[0] = 15; s_col[0] = 7; s_vld[4] = 1; s_row[4] = 1; s_col[4] = 2;
      run_snap("R4 fn on", 0, 1, 1, 15, 7, 100);
      check(got_n >= 1 && got_code[got_n-1] == 138 && got_prs[got_n-1] == 1, "R4", "banked code", got_code[got_n-1], 138);
      run_snap("R4 fn off", 0, 1, 0, 15, 7, 100);
      check(got_n >= 2 && got_code[got_n-2] == 127, "R4", "fn as plain key", got_code[got_n-2], 127);

      // R5: ghost drop with a held set, then probe the kept set
      clear_slots(); s_vld[0] = 1; s_row[0] = 3; s_col[0] = 3;
      run_snap("R5 load", 0, 1, 0, 0, 0, 100);
      clear_slots(); s_vld[0] = 1; s_row[0] = 0; s_col[0] = 0; s_vld[1] = 1; s_row[1] = 0; s_col[1] = 1;
      s_vld[2] = 1; s_row[2] = 1; s_col[2] = 0;
      run_snap("R5 ghost", 0, 1, 0, 0, 0, 100);
      clear_slots(); s_vld[6] = 1; s_row[6] = 9; s_col[6] = 1;
      run_snap("R5 probe", 0, 1, 0, 0, 0, 100);
      check(got_n == 2 && got_code[0] == 27 && got_prs[0] == 0, "R5", "held set kept across drop", got_code[0], 27);

      // R6: same shape without filtering, and a row-only triple with filtering
      clear_slots(); s_vld[0] = 1; s_row[0] = 0; s_col[0] = 0; s_vld[1] = 1; s_row[1] = 0; s_col[1] = 1;
      s_vld[2] = 1; s_row[2] = 1; s_col[2] = 0;
      run_snap("R6 filter off", 0, 0, 0, 0, 0, 100);
      check(got_n == 4, "R6", "unfiltered ghost shape", got_n, 4);
      clear_slots(); s_vld[0] = 1; s_row[0] = 4; s_col[0] = 0; s_vld[1] = 1; s_row[1] = 4; s_col[1] = 1;
      s_vld[2] = 1; s_row[2] = 4; s_col[2] = 2;
      run_snap("R6 row only", 0, 1, 0, 0, 0, 100);
      check(got_n == 6, "R6", "row-only triple accepted", got_n, 6);

      // R7: empty releases all, slots ignored; then an empty set again gives only a sync
      run_snap("R7 empty", 1, 1, 0, 0, 0, 60);
      check(got_n == 3 && got_prs[0] == 0 && got_prs[2] == 0, "R7", "all released", got_n, 3);
      run_snap("R9 nothing", 1, 1, 0, 0, 0, 100);
      check(got_n == 0, "R9", "sync without events", got_n, 0);

      // random mix on a small corner of the matrix
      for (int t = 0; t < 400; t++) begin
         bit e, g, f;
         for (int i = 0; i < ENTRIES; i++) begin
            s_vld[i] = (($urandom % 3) == 0) ? 1 : 0;
            s_row[i] = $urandom % 4;
            s_col[i] = $urandom % 4;
         end
         e = (($urandom % 16) == 0);
         g = (($urandom % 2) == 0);
         f = (($urandom % 2) == 0);
         run_snap("R3 random", e, g, f, 2, 2, 20 + ($urandom % 81));
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule